// File: doc/BRIEF.md
# GPIO interrupt channel router

This block takes a wide bank of GPIO pad inputs and steers a chosen subset of them onto eight interrupt lines. Each line has a pad-select mux, an optional debounce filter and a trigger conditioner. The conditioner presents a high level or a one-cycle high pulse to a downstream interrupt controller, which therefore only needs to understand active-high levels and rising pulses. Falling-edge and low-level sources are inverted in the conditioner. A both-edge mode reports every transition, whatever the other trigger settings for that line say.

Software programs four 32-bit words over a simple single-cycle bus. A write lands on the clock edge where `bus_wen` is high. A read returns the addressed word combinationally on `bus_rdata`. Each pad first passes through a two-stage synchroniser. The filter on each line is a two-state machine: `FLT_IDLE` waits for the synchronised input to differ from the accepted level. `FLT_IDLE -> FLT_CHECK` happens when it differs and the length is above one. `FLT_CHECK -> FLT_IDLE` happens either when the input falls back (rejected) or when the run reaches the programmed length (accepted). The conditioner decodes one of five modes: `TRG_HIGH`, `TRG_LOW`, `TRG_RISE`, `TRG_FALL` and `TRG_BOTH`.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register word reads 0, every line selects pad 0 in high-level mode, and `irq_out` is 0 while the pads are low.
- R2: Line n takes its pad index from word 1 (n < 4) or word 2 (n >= 4), in bits [(n mod 4)*8 +: 8]. A line follows only the pad it selects.
- R3: With bit n and bit 8+n of word 0 clear, `irq_out[n]` follows the selected pad level. It updates on the 3rd rising clock edge after the pad changes when the filter length is 0.
- R4: With bit n of word 0 set, bit 8+n clear and bit 16+n clear, `irq_out[n]` is high for exactly one cycle after each rising pad transition. A falling pad transition produces no pulse.
- R5: Bit 16+n of word 0 inverts line n. In level mode `irq_out[n]` is then high while the pad is low. In edge mode it pulses on falling transitions only.
- R6: With bit 8+n of word 0 set, line n pulses for one cycle on every transition of its pad, and bits n and 16+n have no effect.
- R7: A pad index at or above the number of implemented pads feeds a constant 0 into that line's conditioner.
- R8: Bits 31:24 of word 0 ignore writes and always read 0.
- R9: Word 3 bits [4n +: 4] hold the filter length F for line n. With F > 0, a new synchronised level must persist for F consecutive cycles before the conditioner sees it, so the output moves on edge 3+F. Shorter runs are dropped. F = 0 bypasses the filter.
- R10: Words 1, 2 and 3 read back exactly what was last written to them. Word 0 reads back its 24 implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NUM_PADS | Asynchronous pad levels |
| bus_wen | input | 1 | Write strobe for the addressed word |
| bus_word | input | 2 | Word index: 0 trigger, 1 select lines 0-3, 2 select lines 4-7, 3 filter |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_out | output | 8 | Active-high interrupt lines toward the controller |

## Verification
The bench times the level path exactly. A design with a missing or extra pipeline stage shows the new level one edge early or late and fails the timing checks. Edge checks watch a pad move in the direction that must not pulse. This catches a conditioner that detects both edges, or that flips polarity on the wrong bit. It also catches a conditioner that compares the inverted value across a mode change. Both-edge mode is exercised with the edge and inversion bits also set, so a design that lets those bits win loses one of the two pulses. The filter is fed a run one cycle shorter than its length, then a long one. An off-by-one counter either passes the short run or moves the long one on the wrong edge. A pad index just below and one far above the pad count shows whether an out-of-range select leaks anything other than 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CH_NUM = 8;
    localparam int SEL_W  = 8;
    localparam int FLT_W  = 4;
    localparam int DATA_W = 32;
    localparam int SEL_SPAN = 1 << SEL_W;
    localparam int CH_PER_WORD = DATA_W / SEL_W;

    typedef enum logic [1:0] {
        W_TRIG   = 2'd0,
        W_SEL_LO = 2'd1,
        W_SEL_HI = 2'd2,
        W_FILT   = 2'd3
    } reg_word_e;

    typedef enum logic {
        FLT_IDLE  = 1'b0,
        FLT_CHECK = 1'b1
    } flt_state_e;

    typedef enum logic [2:0] {
        TRG_HIGH = 3'd0,
        TRG_LOW  = 3'd1,
        TRG_RISE = 3'd2,
        TRG_FALL = 3'd3,
        TRG_BOTH = 3'd4
    } trg_mode_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wen_i,
    input  logic [1:0]                       word_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [DATA_W-1:0]                rdata_o,
    output logic [CH_NUM-1:0]                edge_en_o,
    output logic [CH_NUM-1:0]                both_en_o,
    output logic [CH_NUM-1:0]                inv_en_o,
    output logic [CH_NUM-1:0][SEL_W-1:0]     sel_o,
    output logic [CH_NUM-1:0][FLT_W-1:0]     flt_len_o
);
    localparam int SEL_BITS = CH_NUM * SEL_W;
    localparam int FLT_BITS = CH_NUM * FLT_W;

    logic [CH_NUM-1:0]   edge_q, both_q, inv_q;
    logic [SEL_BITS-1:0] sel_q;
    logic [FLT_BITS-1:0] flt_q;
    reg_word_e           word;

    assign word = reg_word_e'(word_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            both_q <= '0;
            inv_q  <= '0;
            sel_q  <= '0;
            flt_q  <= '0;
        end else if (wen_i) begin
            unique case (word)
                W_TRIG: begin
                    edge_q <= wdata_i[CH_NUM-1:0];
                    both_q <= wdata_i[2*CH_NUM-1:CH_NUM];
                    inv_q  <= wdata_i[3*CH_NUM-1:2*CH_NUM];
                end
                W_SEL_LO: sel_q[DATA_W-1:0]        <= wdata_i;
                W_SEL_HI: sel_q[2*DATA_W-1:DATA_W] <= wdata_i;
                W_FILT:   flt_q                    <= wdata_i;
            endcase
        end
    end

    always_comb begin
        unique case (word)
            W_TRIG:   rdata_o = {{(DATA_W-3*CH_NUM){1'b0}}, inv_q, both_q, edge_q};
            W_SEL_LO: rdata_o = sel_q[DATA_W-1:0];
            W_SEL_HI: rdata_o = sel_q[2*DATA_W-1:DATA_W];
            W_FILT:   rdata_o = flt_q;
        endcase
    end

    assign edge_en_o = edge_q;
    assign both_en_o = both_q;
    assign inv_en_o  = inv_q;
    assign sel_o     = sel_q;
    assign flt_len_o = flt_q;

    AST_TRIG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wen_i && word_i == 2'd0 |=> rdata_o[DATA_W-1:3*CH_NUM] == '0 || word_i != 2'd0); // R8
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_i,
    input  logic [FLT_W-1:0] len_i,
    output logic             out_o
);
    flt_state_e       state_q, state_d;
    logic [FLT_W-1:0] cnt_q, cnt_d;
    logic             acc_q, acc_d;
    logic [FLT_W:0]   run_next;
    logic             bypass;

    assign bypass   = (len_i == '0);
    assign run_next = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_IDLE;
            cnt_q   <= '0;
            acc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            acc_q   <= acc_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        acc_d   = acc_q;
        if (bypass) begin
            state_d = FLT_IDLE;
            cnt_d   = '0;
            acc_d   = in_i;
        end else begin
            unique case (state_q)
                FLT_IDLE: begin
                    if (in_i != acc_q) begin
                        if (len_i == FLT_W'(1)) begin
                            acc_d = in_i;
                        end else begin
                            state_d = FLT_CHECK;
                            cnt_d   = FLT_W'(1);
                        end
                    end
                end
                FLT_CHECK: begin
                    if (in_i == acc_q) begin
                        state_d = FLT_IDLE;
                        cnt_d   = '0;
                    end else if (run_next >= {1'b0, len_i}) begin
                        state_d = FLT_IDLE;
                        cnt_d   = '0;
                        acc_d   = in_i;
                    end else begin
                        cnt_d = run_next[FLT_W-1:0];
                    end
                end
            endcase
        end
    end

    assign out_o = bypass ? in_i : acc_q;

    AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        len_i != '0 && in_i == acc_q |=> acc_q == $past(acc_q)); // R9
endmodule

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic edge_en_i,
    input  logic both_en_i,
    input  logic inv_en_i,
    output logic irq_o
);
    trg_mode_e mode;
    logic      prev_q;
    logic      irq_q, irq_d;

    always_comb begin
        if (both_en_i)      mode = TRG_BOTH;
        else if (edge_en_i) mode = inv_en_i ? TRG_FALL : TRG_RISE;
        else                mode = inv_en_i ? TRG_LOW  : TRG_HIGH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            irq_q  <= irq_d;
        end
    end

    always_comb begin
        unique case (mode)
            TRG_HIGH: irq_d = lvl_i;
            TRG_LOW:  irq_d = !lvl_i;
            TRG_RISE: irq_d = lvl_i && !prev_q;
            TRG_FALL: irq_d = !lvl_i && prev_q;
            TRG_BOTH: irq_d = lvl_i != prev_q;
            default:  irq_d = 1'b0;
        endcase
    end

    assign irq_o = irq_q;

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_en_i && !both_en_i |=> irq_q == ($past(lvl_i) ^ $past(inv_en_i))); // R3
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && edge_en_i && !both_en_i
        |=> !irq_q || !$stable({edge_en_i, both_en_i, inv_en_i})); // R4
    AST_BOTH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        both_en_i && lvl_i == prev_q |=> !irq_q); // R6
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PADS    = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic                bus_wen,
    input  logic [1:0]          bus_word,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [7:0]          irq_out
);
    logic [NUM_PADS-1:0]         pad_sync;
    logic [SEL_SPAN-1:0]         pad_wide;
    logic [CH_NUM-1:0]           edge_en, both_en, inv_en;
    logic [CH_NUM-1:0][SEL_W-1:0] sel;
    logic [CH_NUM-1:0][FLT_W-1:0] flt_len;
    logic [CH_NUM-1:0]           mux_lvl, flt_lvl;

    gpio_irq_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pad_sync)
    );

    gpio_irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wen_i(bus_wen), .word_i(bus_word),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .edge_en_o(edge_en), .both_en_o(both_en), .inv_en_o(inv_en),
        .sel_o(sel), .flt_len_o(flt_len)
    );

    // Unimplemented pad indices read as constant 0 (R7)
    always_comb begin
        pad_wide = '0;
        pad_wide[NUM_PADS-1:0] = pad_sync;
    end

    for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
        assign mux_lvl[ch] = pad_wide[sel[ch]];

        gpio_irq_filter u_flt (
            .clk(clk), .rst_n(rst_n), .in_i(mux_lvl[ch]),
            .len_i(flt_len[ch]), .out_o(flt_lvl[ch])
        );

        gpio_irq_trigger u_trg (
            .clk(clk), .rst_n(rst_n), .lvl_i(flt_lvl[ch]),
            .edge_en_i(edge_en[ch]), .both_en_i(both_en[ch]),
            .inv_en_i(inv_en[ch]), .irq_o(irq_out[ch])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_out == '0); // R1
endmodule

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PADS   = 200;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_PADS-1:0] pad_in = '0;
    logic                bus_wen = 1'b0;
    logic [1:0]          bus_word = 2'd0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [7:0]          irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    gpio_irq_router #(.NUM_PADS(NUM_PADS)) uut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .bus_wen(bus_wen),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] w, input logic [31:0] exp, input string req);
        bus_word = w;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    // Watch line ch for n cycles; report whether it was ever high
    task automatic watch(input int ch, input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (irq_out[ch]) seen = 1'b1;
        end
    endtask

    task automatic t_reset;
        check(irq_out == 8'h00, "R1 irq after reset", irq_out, 0);
        for (int w = 0; w < 4; w++) rd_check(2'(w), 32'h0, "R1 register reset");
    endtask

    task automatic t_regs;
        wr(2'd0, 32'hFFFF_FFFF);
        rd_check(2'd0, 32'h00FF_FFFF, "R8 trigger top byte");
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h1234_5678);
        rd_check(2'd3, 32'h1234_5678, "R10 filter readback");
        wr(2'd3, 32'h0);
        wr(2'd1, 32'h0003_0000);   // line 2 -> pad 3
        wr(2'd2, 32'h0000_4D00);   // line 5 -> pad 77
        rd_check(2'd2, 32'h0000_4D00, "R10 select readback");
        step(4);
    endtask

    task automatic t_mux;
        pad_in[77] = 1'b1;
        step(2);
        check(irq_out[5] == 1'b0, "R3 level not before third edge", irq_out, 0);
        step(1);
        check(irq_out == 8'h20, "R2/R3 line5 follows pad77", irq_out, 8'h20);
        pad_in[3] = 1'b1;
        step(3);
        check(irq_out == 8'h24, "R2 line2 follows pad3", irq_out, 8'h24);
        pad_in[0] = 1'b1;
        step(3);
        check(irq_out == 8'hFF, "R2 default lines on pad0", irq_out, 8'hFF);
        pad_in = '0;
        step(3);
        check(irq_out == 8'h00, "R3 all low again", irq_out, 0);
    endtask

    task automatic t_level_low;
        wr(2'd0, 32'h0020_0000);   // invert line 5
        step(1);
        check(irq_out[5] == 1'b1, "R5 low-level active with pad low", irq_out[5], 1);
        pad_in[77] = 1'b1;
        step(3);
        check(irq_out[5] == 1'b0, "R5 low-level idle with pad high", irq_out[5], 0);
        pad_in[77] = 1'b0;
        wr(2'd0, 32'h0);
        step(4);
    endtask

    task automatic t_edge;
        bit seen;
        wr(2'd0, 32'h0000_0020);   // rising edge on line 5
        step(2);
        pad_in[77] = 1'b1;
        step(3);
        check(irq_out[5] == 1'b1, "R4 rising pulse", irq_out[5], 1);
        step(1);
        check(irq_out[5] == 1'b0, "R4 pulse one cycle", irq_out[5], 0);
        watch(5, 3, seen);
        check(!seen, "R4 no pulse while high", seen, 0);
        pad_in[77] = 1'b0;
        watch(5, 6, seen);
        check(!seen, "R4 falling ignored", seen, 0);
    endtask

    task automatic t_falling;
        bit seen;
        wr(2'd0, 32'h0020_0020);   // falling edge on line 5
        step(2);
        pad_in[77] = 1'b1;
        watch(5, 6, seen);
        check(!seen, "R5 rising ignored in falling mode", seen, 0);
        pad_in[77] = 1'b0;
        step(3);
        check(irq_out[5] == 1'b1, "R5 falling pulse", irq_out[5], 1);
        step(1);
        check(irq_out[5] == 1'b0, "R5 falling pulse one cycle", irq_out[5], 0);
    endtask

    task automatic t_both;
        wr(2'd0, 32'h0020_2020);   // both-edge with edge and invert also set
        step(2);
        pad_in[77] = 1'b1;
        step(3);
        check(irq_out[5] == 1'b1, "R6 rise pulse", irq_out[5], 1);
        step(1);
        check(irq_out[5] == 1'b0, "R6 rise pulse one cycle", irq_out[5], 0);
        pad_in[77] = 1'b0;
        step(3);
        check(irq_out[5] == 1'b1, "R6 fall pulse", irq_out[5], 1);
        step(1);
        check(irq_out[5] == 1'b0, "R6 fall pulse one cycle", irq_out[5], 0);
        wr(2'd0, 32'h0);
        step(3);
    endtask

    task automatic t_range;
        pad_in[199] = 1'b1;
        wr(2'd0, 32'h0080_0000);   // invert line 7, level mode
        wr(2'd2, 32'hC700_4D00);   // line 7 -> pad 199
        step(2);
        check(irq_out[7] == 1'b0, "R7 last pad selectable", irq_out[7], 0);
        wr(2'd2, 32'hFA00_4D00);   // line 7 -> pad 250, unimplemented
        step(1);
        check(irq_out[7] == 1'b1, "R7 out of range is zero", irq_out[7], 1);
        pad_in = '1;
        step(4);
        check(irq_out[7] == 1'b1, "R7 out of range ignores pads", irq_out[7], 1);
        pad_in = '0;
        wr(2'd0, 32'h0);
        step(4);
    endtask

    task automatic t_filter;
        bit seen;
        wr(2'd3, 32'h0030_0000);   // line 5 filter length 3
        step(2);
        pad_in[77] = 1'b1;
        step(2);
        pad_in[77] = 1'b0;
        watch(5, 8, seen);
        check(!seen, "R9 short run dropped", seen, 0);
        pad_in[77] = 1'b1;
        step(5);
        check(irq_out[5] == 1'b0, "R9 not before edge 3+F", irq_out[5], 0);
        step(1);
        check(irq_out[5] == 1'b1, "R9 accepted on edge 3+F", irq_out[5], 1);
        pad_in[77] = 1'b0;
        wr(2'd3, 32'h0);
        step(4);
        check(irq_out[5] == 1'b0, "R9 bypass after clear", irq_out[5], 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regs();
        t_mux();
        t_level_low();
        t_edge();
        t_falling();
        t_both();
        t_range();
        t_filter();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule